// File: doc/BRIEF.md
# Row/Column Multiplexed Memory Access Sequencer

The block sits between a processor-side request port and a RAM whose address pins are shared between a row half and a column half. It takes one request at a time, either a read or a write, each carrying a 16-bit word address and, for writes, a data byte. It drives the RAM's 8 shared address pins, a row strobe, a column strobe, a write enable, a read enable and the write data lines. It keeps the access controls asserted for a number of clock cycles that covers the RAM's access time.

On acceptance the address and the write data are captured. The block then presents the upper address half with the row strobe for one cycle. Next it presents the lower half and adds the column strobe. After that it asserts the write or read control for a fixed hold count. The hold count is the clock-period ceiling of the access time, which gives 3 cycles for 50 ns at 20 ns. A read returns its data with a one-cycle valid pulse. While an access is in flight, `ready` stays low and any request is refused.

Top module: `rc_mem_seq`

## Requirements
- R1: After reset, `ready` is 1 and `row_stb`, `col_stb`, `wr_en`, `rd_en` and `rvalid` are all 0.
- R2: A request (`req`=1) is taken only on a rising clock edge where `ready` is 1. A request made while `ready` is 0 has no effect on the RAM contents.
- R3: In the first cycle after acceptance, `mem_a` carries address bits [15:8] and `row_stb` rises alone. The column strobe is not asserted in that cycle.
- R4: `col_stb` rises in the cycle after `row_stb`, with `mem_a` equal to address bits [7:0]. `col_stb` is only ever 1 while `row_stb` is 1, and `mem_a` does not change while `col_stb` stays 1.
- R5: For a write, `mem_wd` already holds the write data when `wr_en` rises. `wr_en` is only ever 1 while `col_stb` is 1.
- R6: For a read, `rd_en` is asserted under both strobes. `rdata` is the RAM's `mem_rd` value sampled at the end of the last hold cycle, and `rvalid` is a single-cycle pulse carrying it. Writes never raise `rvalid`.
- R7: The hold count is HOLD = ceil(ACCESS_NS / CLK_NS), which is 3 by default. `wr_en` and `rd_en` each stay high for exactly HOLD consecutive cycles, and the strobes fall only after that count expires.
- R8: `ready` falls at acceptance. For a read, `rvalid` is 1 in cycle 3+HOLD counted from the acceptance edge. `ready` returns to 1 one cycle later, and writes take the same total time.
- R9: The address and write data are captured at acceptance. Changing `addr`, `wdata` or `we` during an access does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request valid |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Word address: [15:8] row, [7:0] column |
| wdata | input | 8 | Write data |
| ready | output | 1 | Idle and able to accept a request |
| rvalid | output | 1 | Read data valid pulse |
| rdata | output | 8 | Read data |
| mem_a | output | 8 | Shared row/column address pins |
| row_stb | output | 1 | Row address strobe, active high |
| col_stb | output | 1 | Column address strobe, active high |
| wr_en | output | 1 | RAM write control, active high |
| rd_en | output | 1 | RAM read control, active high |
| mem_wd | output | 8 | Data driven to the RAM |
| mem_rd | input | 8 | Data returned by the RAM |

## Verification
The embedded assertions check the following on every cycle:
- the strobe nesting (column only under row, a control only under the column strobe);
- the row-before-column order;
- the stability of the pins under the column strobe;
- the release of the strobes only at the end of the hold count;
- the single-cycle valid pulse.

Only the bench scenarios can show the rest, using a RAM model that latches the row and column on strobe edges:
- that the correct address halves and data reach the RAM;
- that read data round-trips;
- that requests made while busy and inputs changed mid-access leave the stored contents untouched;
- the end-to-end latency.

// File: rtl/rc_mem_seq.sv
module rc_mem_seq #(
  parameter int ROW_W     = 8,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 20,
  parameter int ACCESS_NS = 50
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   we,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic                   ready,
  output logic                   rvalid,
  output logic [DATA_W-1:0]      rdata,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] mem_a,
  output logic                   row_stb,
  output logic                   col_stb,
  output logic                   wr_en,
  output logic                   rd_en,
  output logic [DATA_W-1:0]      mem_wd,
  input  logic [DATA_W-1:0]      mem_rd
);
  localparam int ADDR_W   = ROW_W + COL_W;
  localparam int PIN_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int HOLD_RAW = (ACCESS_NS + CLK_NS - 1) / CLK_NS;
  localparam int HOLD     = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int CNT_W    = (HOLD > 1) ? $clog2(HOLD) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_WAIT, S_DONE} st_t;

  st_t               st;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic              we_q;
  logic [CNT_W-1:0]  cnt;
  logic              last;

  assign last = (cnt == CNT_W'(HOLD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      a_q   <= '0;
      d_q   <= '0;
      we_q  <= 1'b0;
      cnt   <= '0;
      rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          a_q  <= addr;
          d_q  <= wdata;
          we_q <= we;
          st   <= S_ROW;
        end
        S_ROW:  st <= S_COL;
        S_COL: begin
          cnt <= '0;
          st  <= S_WAIT;
        end
        S_WAIT: begin
          if (last) begin
            if (!we_q) rdata <= mem_rd;
            st <= S_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready   = (st == S_IDLE);
  assign row_stb = (st == S_ROW) || (st == S_COL) || (st == S_WAIT);
  assign col_stb = (st == S_COL) || (st == S_WAIT);
  assign wr_en   = (st == S_WAIT) && we_q;
  assign rd_en   = (st == S_WAIT) && !we_q;
  assign rvalid  = (st == S_DONE) && !we_q;
  assign mem_wd  = d_q;
  assign mem_a   = (st == S_ROW) ? PIN_W'(a_q[ADDR_W-1:COL_W]) : PIN_W'(a_q[COL_W-1:0]);

  a_r4_col_under_row: assert property (@(posedge clk) disable iff (!rst_n)
    col_stb |-> row_stb);
  a_r5_ctrl_under_col: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |-> col_stb);
  a_r3_row_before_col: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_stb) |-> $past(row_stb && !col_stb));
  a_r4_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb && $past(col_stb)) |-> $stable(mem_a));
  a_r7_release_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(col_stb) |-> $past(cnt) == CNT_W'(HOLD - 1));
  a_r6_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  a_r2_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |-> !ready);
endmodule

// File: tb/rc_mem_seq_test.sv
module rc_mem_seq_test;
  localparam int CLK_PERIOD = 20;
  localparam int HOLD = 3;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [15:0] addr = 0;
  logic [7:0] wdata = 0, mem_rd = 0;
  logic ready, rvalid, row_stb, col_stb, wr_en, rd_en;
  logic [7:0] rdata, mem_a, mem_wd;

  int checks = 0, fails = 0;
  logic [15:0] cur_addr = 0;
  logic [7:0]  cur_data = 0;
  logic [7:0]  ref_mem [int];
  logic [7:0]  ram [int];

  rc_mem_seq uut (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .ready(ready), .rvalid(rvalid), .rdata(rdata), .mem_a(mem_a),
    .row_stb(row_stb), .col_stb(col_stb), .wr_en(wr_en), .rd_en(rd_en),
    .mem_wd(mem_wd), .mem_rd(mem_rd));

  always #(CLK_PERIOD/2) clk = ~clk;

  // RAM model: latches halves on strobe edges
  logic [7:0] m_row = 0, m_col = 0;
  logic m_rp = 0, m_cp = 0;
  always @(posedge clk) begin
    if (row_stb && !m_rp) m_row <= mem_a;
    if (col_stb && !m_cp) m_col <= mem_a;
    m_rp <= row_stb;
    m_cp <= col_stb;
    if (wr_en) ram[{m_row, m_col}] = mem_wd;
    if (rd_en) mem_rd <= ram.exists({m_row, m_col}) ? ram[{m_row, m_col}] : 8'h00;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  // Protocol monitor, sampled at negedge
  logic p_row = 0, p_col = 0, p_wr = 0, p_rd = 0;
  int run = 0;
  always @(negedge clk) if (rst_n) begin
    if (row_stb && !p_row) chk(mem_a == cur_addr[15:8] && !col_stb, "R3 row half", mem_a, cur_addr[15:8]);
    if (col_stb && !p_col) chk(mem_a == cur_addr[7:0] && p_row, "R4 column half", mem_a, cur_addr[7:0]);
    if (wr_en && !p_wr) chk(mem_wd == cur_data && col_stb, "R5 data before write", mem_wd, cur_data);
    if (wr_en || rd_en) run++;
    if ((p_wr && !wr_en) || (p_rd && !rd_en)) begin
      chk(run == HOLD, "R7 hold length", run, HOLD);
      run = 0;
    end
    if (p_col && !col_stb) chk(!p_wr && !p_rd || run == 0, "R7 strobe after hold", run, 0);
    p_row = row_stb; p_col = col_stb; p_wr = wr_en; p_rd = rd_en;
  end

  // One access; optionally inject a request while busy
  task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d,
                        input bit inject, input logic [15:0] ia, input logic [7:0] id);
    int n = 0, rv_at = -1, rd_at = -1;
    logic [7:0] got = 0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    cur_addr = a; cur_data = d;
    req = 1; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = ~w; addr = $urandom; wdata = $urandom;   // R9 disturbance
    while (rd_at < 0 && n < 40) begin
      @(negedge clk); n++;
      if (inject && n == 2) begin req = 1; we = 1; addr = ia; wdata = id; end
      if (inject && n == 3) req = 0;
      if (rvalid && rv_at < 0) begin rv_at = n; got = rdata; end
      if (ready) rd_at = n;
    end
    chk(rd_at == HOLD + 4, "R8 ready return", rd_at, HOLD + 4);
    if (w) begin
      ref_mem[a] = d;
      chk(rv_at == -1, "R6 no rvalid on write", rv_at, -1);
    end else begin
      chk(rv_at == HOLD + 3, "R8 read latency", rv_at, HOLD + 3);
      chk(got == exp_read(a), "R6 read data", got, exp_read(a));
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(ready == 1 && !row_stb && !col_stb && !wr_en && !rd_en && !rvalid, "R1 reset",
        {ready, row_stb, col_stb, wr_en, rd_en, rvalid}, 6'b100000);
    rst_n = 1;
    // corners
    access(1, 16'h0000, 8'hA5, 0, 0, 0);
    access(1, 16'hFFFF, 8'h3C, 0, 0, 0);
    access(0, 16'h0000, 0, 0, 0, 0);
    access(0, 16'hFFFF, 0, 0, 0, 0);
    access(0, 16'h00FF, 0, 0, 0, 0);
    // R2: request while busy is ignored
    access(1, 16'h1234, 8'h55, 1, 16'h4321, 8'hAA);
    access(0, 16'h4321, 0, 0, 0, 0);
    chk(exp_read(16'h4321) == 8'h00, "R2 busy request ignored", exp_read(16'h4321), 0);
    access(0, 16'h1234, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [15:0] a;
      int k;
      k = ref_mem.num();
      a = {4'h8, 12'($urandom)};
      if (($urandom % 2) == 0) access(1, a, 8'($urandom), 0, 0, 0);
      else access(0, a, 0, 0, 0, 0);
      if (k < 0) a = 0;
    end
    finish_run();
  end
endmodule